// File: doc/BRIEF.md
# Outbound PCI Window Decoder

This block sits between a CPU-side bus, a PCI bus and a small set of configuration registers of a host bridge. On the outbound path it compares each CPU memory request with thirty 8 MiB windows that follow one another from 0xF0800000 to 0xFF7FFFFF. A request that lands in a window whose enable bit is set, while forwarding is switched on, is flagged as a hit. The address is passed to PCI memory space unchanged, together with the window number.

On the inbound path the block classifies each PCI bus-master address as bound for system memory, for PCI memory, for the CPU-local region, or for nowhere (a decode miss). Two configuration words are held in registers: a control word, whose bits [8:7] switch outbound forwarding on when they hold 2'b01, and a 32-bit window enable mask. The edge bits of the mask are always read as clear. Both decodes are combinational from the request inputs and the registered configuration. A configuration write therefore governs every request from the cycle after its capturing clock edge.

Top module: `pci_window_decoder`

## Requirements
- R1: After reset the control field and the enable mask are zero, so no CPU request hits any window.
- R2: Outbound forwarding is on only while the registered control bits [8:7] equal 2'b01; the codes 2'b00, 2'b10 and 2'b11 keep `cpu_hit` low for every address and mask.
- R3: With forwarding on, a CPU request at address A with A[31:28] = 4'hF hits window n = A[27:23] exactly when mask bit n is set and 1 <= n <= 30; `cpu_win_idx` then equals n.
- R4: Mask bit 0 (window at 0xF0000000) and mask bit 31 (window at 0xFF800000) have no effect; requests in those two chunks never hit, even with an all-ones mask.
- R5: On a hit `pci_fwd_addr` equals `cpu_addr` with no offset; when there is no hit it is zero.
- R6: A write to either configuration word, captured at a rising edge, first affects the request presented in the following cycle; a request in the cycle of the write is decoded with the old value.
- R7: CPU addresses below 0xF0000000 never hit.
- R8: A bus-master request below 0xF0800000 selects system memory.
- R9: A bus-master request in 0xF0800000 to 0xFF7FFFFF selects PCI memory, whatever the outbound window configuration.
- R10: A bus-master request in 0xFFF00000 to 0xFFFFEFFF selects the CPU-local region.
- R11: Any other bus-master request raises `bm_miss`; while `bm_req` is high exactly one of the four inbound outputs is high.
- R12: With `cpu_req` low `cpu_hit` is low, and with `bm_req` low all four inbound outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl_we | input | 1 | Write strobe for the control word |
| cfg_ctrl_wdata | input | 32 | Control word; bits [8:7] are the forwarding code |
| cfg_mask_we | input | 1 | Write strobe for the window enable mask |
| cfg_mask_wdata | input | 32 | Window enable mask, bit n for window n |
| cpu_req | input | 1 | CPU memory request valid |
| cpu_addr | input | 32 | CPU memory address |
| cpu_hit | output | 1 | Request falls in an enabled outbound window |
| cpu_win_idx | output | 5 | Number of the window hit (zero when no hit) |
| pci_fwd_addr | output | 32 | Address issued on PCI memory space on a hit |
| bm_req | input | 1 | PCI bus-master request valid |
| bm_addr | input | 32 | PCI bus-master address |
| bm_sel_sysmem | output | 1 | Inbound request targets system memory |
| bm_sel_pcimem | output | 1 | Inbound request targets PCI memory |
| bm_sel_cpulocal | output | 1 | Inbound request targets the CPU-local region |
| bm_miss | output | 1 | Inbound request falls in no region |

## Verification
The case that needs care is a configuration write and a CPU request in the same cycle. The bench provokes it by raising the control or mask write strobe in the cycle in which a request to a window is held. It expects the hit decision of that cycle to follow the old configuration, and the decision after the capturing edge to follow the new one. A second overlap, an inbound request in the same cycle as an outbound one and as a window reconfiguration, is driven to show that the inbound classification does not depend on the window state.

// File: rtl/pci_window_decoder_pkg.sv
package pci_window_decoder_pkg;

  typedef enum logic [1:0] {
    BM_TGT_SYSMEM   = 2'd0,
    BM_TGT_PCIMEM   = 2'd1,
    BM_TGT_CPULOCAL = 2'd2,
    BM_TGT_NONE     = 2'd3
  } bm_target_e;

  localparam int unsigned BM_TGT_COUNT = 4;

endpackage

// File: rtl/pwd_cfg_regs.sv
module pwd_cfg_regs #(
  parameter int unsigned CTRL_W    = 32,
  parameter int unsigned FIELD_LSB = 7,
  parameter logic [1:0]  FWD_CODE  = 2'b01,
  parameter int unsigned MASK_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              mask_we,
  input  logic [MASK_W-1:0] mask_wdata,
  output logic              fwd_on,
  output logic [MASK_W-1:0] win_en
);

  localparam int unsigned LAST = MASK_W - 1;

  logic [1:0]        field_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= 2'b00;
      mask_q  <= '0;
    end else begin
      if (ctrl_we) field_q <= ctrl_wdata[FIELD_LSB +: 2];
      if (mask_we) mask_q  <= mask_wdata;
    end
  end

  assign fwd_on = (field_q == FWD_CODE);

  // Edge windows are never forwardable; inner ones follow mask and global gate.
  for (genvar g = 0; g < MASK_W; g++) begin : g_win
    if (g == 0 || g == LAST) begin : g_edge
      assign win_en[g] = 1'b0;
    end else begin : g_inner
      assign win_en[g] = fwd_on & mask_q[g];
    end
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{ctrl_wdata, mask_q[0], mask_q[LAST]};

endmodule

// File: rtl/pwd_cpu_decode.sv
module pwd_cpu_decode #(
  parameter int unsigned  ADDR_W     = 32,
  parameter int unsigned  CHUNK_LOG2 = 23,
  parameter int unsigned  IDX_W      = 5,
  parameter logic [31:0]  WIN_BASE   = 32'hF000_0000
) (
  input  logic                    cpu_req,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [(1<<IDX_W)-1:0]   win_en,
  output logic                    in_aperture,
  output logic                    hit,
  output logic [IDX_W-1:0]        win_idx,
  output logic [ADDR_W-1:0]       fwd_addr
);

  localparam int unsigned TAG_LSB = CHUNK_LOG2 + IDX_W;
  localparam int unsigned TAG_W   = ADDR_W - TAG_LSB;
  localparam logic [ADDR_W-1:0] BASE = WIN_BASE[ADDR_W-1:0];
  localparam logic [TAG_W-1:0]  TAG  = BASE[ADDR_W-1:TAG_LSB];

  function automatic logic [IDX_W-1:0] chunk_of(input logic [ADDR_W-1:0] a);
    return a[CHUNK_LOG2 +: IDX_W];
  endfunction

  logic [IDX_W-1:0] idx_raw;

  assign in_aperture = (cpu_addr[ADDR_W-1:TAG_LSB] == TAG);
  assign idx_raw     = chunk_of(cpu_addr);
  assign hit         = cpu_req & in_aperture & win_en[idx_raw];
  assign win_idx     = hit ? idx_raw : '0;
  assign fwd_addr    = hit ? cpu_addr : '0;

endmodule

// File: rtl/pwd_bm_decode.sv
module pwd_bm_decode
  import pci_window_decoder_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter logic [31:0] PCI_LO      = 32'hF080_0000,
  parameter logic [31:0] PCI_END     = 32'hFF80_0000,
  parameter logic [31:0] LOCAL_LO    = 32'hFFF0_0000,
  parameter logic [31:0] LOCAL_HI    = 32'hFFFF_EFFF
) (
  input  logic              bm_req,
  input  logic [ADDR_W-1:0] bm_addr,
  output bm_target_e        target,
  output logic [BM_TGT_COUNT-1:0] sel
);

  localparam logic [ADDR_W-1:0] P_LO  = PCI_LO[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] P_END = PCI_END[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] L_LO  = LOCAL_LO[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] L_HI  = LOCAL_HI[ADDR_W-1:0];

  function automatic bm_target_e classify(input logic [ADDR_W-1:0] a);
    if (a < P_LO)                    return BM_TGT_SYSMEM;
    else if (a < P_END)              return BM_TGT_PCIMEM;
    else if (a >= L_LO && a <= L_HI) return BM_TGT_CPULOCAL;
    else                             return BM_TGT_NONE;
  endfunction

  assign target = classify(bm_addr);

  for (genvar t = 0; t < BM_TGT_COUNT; t++) begin : g_sel
    assign sel[t] = bm_req & (target == bm_target_e'(t));
  end

endmodule

// File: rtl/pci_window_decoder.sv
module pci_window_decoder
  import pci_window_decoder_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CTRL_W     = 32,
  parameter int unsigned FIELD_LSB  = 7,
  parameter logic [1:0]  FWD_CODE   = 2'b01,
  parameter int unsigned NUM_WIN    = 30,
  parameter int unsigned CHUNK_LOG2 = 23,
  parameter logic [31:0] WIN_BASE   = 32'hF000_0000,
  parameter logic [31:0] LOCAL_LO   = 32'hFFF0_0000,
  parameter logic [31:0] LOCAL_HI   = 32'hFFFF_EFFF,
  localparam int unsigned MASK_W    = NUM_WIN + 2,
  localparam int unsigned IDX_W     = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ctrl_we,
  input  logic [CTRL_W-1:0] cfg_ctrl_wdata,
  input  logic              cfg_mask_we,
  input  logic [MASK_W-1:0] cfg_mask_wdata,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_hit,
  output logic [IDX_W-1:0]  cpu_win_idx,
  output logic [ADDR_W-1:0] pci_fwd_addr,
  input  logic              bm_req,
  input  logic [ADDR_W-1:0] bm_addr,
  output logic              bm_sel_sysmem,
  output logic              bm_sel_pcimem,
  output logic              bm_sel_cpulocal,
  output logic              bm_miss
);

  localparam logic [31:0] CHUNK   = 32'(1) << CHUNK_LOG2;
  localparam logic [31:0] PCI_LO  = WIN_BASE + CHUNK;
  localparam logic [31:0] PCI_END = WIN_BASE + CHUNK * (NUM_WIN + 1);

  // Named internal events, used by the bound checker.
  logic                    fwd_on;
  logic [MASK_W-1:0]       win_en;
  logic                    cpu_in_aperture;
  bm_target_e              bm_target;
  logic [BM_TGT_COUNT-1:0] bm_sel;

  pwd_cfg_regs #(
    .CTRL_W    (CTRL_W),
    .FIELD_LSB (FIELD_LSB),
    .FWD_CODE  (FWD_CODE),
    .MASK_W    (MASK_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (cfg_ctrl_we),
    .ctrl_wdata (cfg_ctrl_wdata),
    .mask_we    (cfg_mask_we),
    .mask_wdata (cfg_mask_wdata),
    .fwd_on     (fwd_on),
    .win_en     (win_en)
  );

  pwd_cpu_decode #(
    .ADDR_W     (ADDR_W),
    .CHUNK_LOG2 (CHUNK_LOG2),
    .IDX_W      (IDX_W),
    .WIN_BASE   (WIN_BASE)
  ) u_cpu (
    .cpu_req     (cpu_req),
    .cpu_addr    (cpu_addr),
    .win_en      (win_en),
    .in_aperture (cpu_in_aperture),
    .hit         (cpu_hit),
    .win_idx     (cpu_win_idx),
    .fwd_addr    (pci_fwd_addr)
  );

  pwd_bm_decode #(
    .ADDR_W   (ADDR_W),
    .PCI_LO   (PCI_LO),
    .PCI_END  (PCI_END),
    .LOCAL_LO (LOCAL_LO),
    .LOCAL_HI (LOCAL_HI)
  ) u_bm (
    .bm_req  (bm_req),
    .bm_addr (bm_addr),
    .target  (bm_target),
    .sel     (bm_sel)
  );

  assign bm_sel_sysmem   = bm_sel[BM_TGT_SYSMEM];
  assign bm_sel_pcimem   = bm_sel[BM_TGT_PCIMEM];
  assign bm_sel_cpulocal = bm_sel[BM_TGT_CPULOCAL];
  assign bm_miss         = bm_sel[BM_TGT_NONE];

endmodule

// File: rtl/pci_window_decoder_sva.sv
module pci_window_decoder_sva #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned CTRL_W    = 32,
  parameter int unsigned FIELD_LSB = 7,
  parameter logic [1:0]  FWD_CODE  = 2'b01,
  parameter int unsigned NUM_WIN   = 30,
  parameter int unsigned IDX_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_ctrl_we,
  input logic [CTRL_W-1:0] cfg_ctrl_wdata,
  input logic              cpu_req,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_hit,
  input logic [IDX_W-1:0]  cpu_win_idx,
  input logic [ADDR_W-1:0] pci_fwd_addr,
  input logic              fwd_on,
  input logic              cpu_in_aperture,
  input logic              bm_req,
  input logic              bm_sel_sysmem,
  input logic              bm_sel_pcimem,
  input logic              bm_sel_cpulocal,
  input logic              bm_miss
);

  a_r2_hit_needs_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> fwd_on);

  a_r2_code_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ctrl_we && cfg_ctrl_wdata[FIELD_LSB +: 2] != FWD_CODE) |=> !cpu_hit);

  a_r4_idx_inner: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> (cpu_win_idx >= 1 && cpu_win_idx <= IDX_W'(NUM_WIN)));

  a_r5_addr_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> (pci_fwd_addr == cpu_addr));

  a_r7_hit_in_aperture: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |-> cpu_in_aperture);

  a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    bm_req |-> $countones({bm_sel_sysmem, bm_sel_pcimem, bm_sel_cpulocal, bm_miss}) == 1);

  a_r12_cpu_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> !cpu_hit);

  a_r12_bm_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bm_req |-> !(bm_sel_sysmem || bm_sel_pcimem || bm_sel_cpulocal || bm_miss));

endmodule

bind pci_window_decoder pci_window_decoder_sva #(
  .ADDR_W    (ADDR_W),
  .CTRL_W    (CTRL_W),
  .FIELD_LSB (FIELD_LSB),
  .FWD_CODE  (FWD_CODE),
  .NUM_WIN   (NUM_WIN),
  .IDX_W     (IDX_W)
) u_sva (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_ctrl_we     (cfg_ctrl_we),
  .cfg_ctrl_wdata  (cfg_ctrl_wdata),
  .cpu_req         (cpu_req),
  .cpu_addr        (cpu_addr),
  .cpu_hit         (cpu_hit),
  .cpu_win_idx     (cpu_win_idx),
  .pci_fwd_addr    (pci_fwd_addr),
  .fwd_on          (fwd_on),
  .cpu_in_aperture (cpu_in_aperture),
  .bm_req          (bm_req),
  .bm_sel_sysmem   (bm_sel_sysmem),
  .bm_sel_pcimem   (bm_sel_pcimem),
  .bm_sel_cpulocal (bm_sel_cpulocal),
  .bm_miss         (bm_miss)
);

// File: tb/pci_window_decoder_tb_top.sv
module pci_window_decoder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MIB8 = 32'h0080_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ctrl_we = 1'b0;
  logic [31:0] cfg_ctrl_wdata = '0;
  logic        cfg_mask_we = 1'b0;
  logic [31:0] cfg_mask_wdata = '0;
  logic        cpu_req = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_hit;
  logic [4:0]  cpu_win_idx;
  logic [31:0] pci_fwd_addr;
  logic        bm_req = 1'b0;
  logic [31:0] bm_addr = '0;
  logic        bm_sel_sysmem, bm_sel_pcimem, bm_sel_cpulocal, bm_miss;

  int checks = 0;
  int failures = 0;
  logic [31:0] m_ctrl = '0;
  logic [31:0] m_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_window_decoder dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_ctrl_we(cfg_ctrl_we), .cfg_ctrl_wdata(cfg_ctrl_wdata),
    .cfg_mask_we(cfg_mask_we), .cfg_mask_wdata(cfg_mask_wdata),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_hit(cpu_hit), .cpu_win_idx(cpu_win_idx), .pci_fwd_addr(pci_fwd_addr),
    .bm_req(bm_req), .bm_addr(bm_addr),
    .bm_sel_sysmem(bm_sel_sysmem), .bm_sel_pcimem(bm_sel_pcimem),
    .bm_sel_cpulocal(bm_sel_cpulocal), .bm_miss(bm_miss)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference: byte-range formulation of the outbound decode.
  function automatic logic ref_hit(input logic [31:0] a);
    logic [31:0] n;
    if (m_ctrl[8:7] != 2'b01) return 1'b0;
    if (a < 32'hF080_0000 || a >= 32'hFF80_0000) return 1'b0;
    n = (a - 32'hF000_0000) / MIB8;
    return m_mask[n];
  endfunction

  function automatic logic [3:0] ref_bm(input logic [31:0] a);
    if (a < 32'hF080_0000) return 4'b0001;
    if (a <= 32'hFF7F_FFFF) return 4'b0010;
    if (a >= 32'hFFF0_0000 && a <= 32'hFFFF_EFFF) return 4'b0100;
    return 4'b1000;
  endfunction

  task automatic wr_cfg(input logic do_ctrl, input logic [31:0] c,
                        input logic do_mask, input logic [31:0] m);
    @(negedge clk);
    cfg_ctrl_we = do_ctrl; cfg_ctrl_wdata = c;
    cfg_mask_we = do_mask; cfg_mask_wdata = m;
    @(negedge clk);
    cfg_ctrl_we = 1'b0; cfg_mask_we = 1'b0;
    if (do_ctrl) m_ctrl = c;
    if (do_mask) m_mask = m;
  endtask

  task automatic probe_cpu(input string req, input logic [31:0] a);
    logic e;
    cpu_req = 1'b1; cpu_addr = a;
    #1;
    e = ref_hit(a);
    check(req, {63'd0, cpu_hit}, {63'd0, e});
    check(req, {59'd0, cpu_win_idx}, e ? {59'd0, a[27:23]} : 64'd0);
    check(req, {32'd0, pci_fwd_addr}, e ? {32'd0, a} : 64'd0);
    cpu_req = 1'b0;
  endtask

  task automatic probe_bm(input string req, input logic [31:0] a);
    bm_req = 1'b1; bm_addr = a;
    #1;
    check(req, {60'd0, bm_miss, bm_sel_cpulocal, bm_sel_pcimem, bm_sel_sysmem},
          {60'd0, ref_bm(a)});
    bm_req = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    probe_cpu("R1 reset state", 32'hF080_0000);
    probe_cpu("R1 reset state", 32'hF800_0000);
  endtask

  task automatic t_gate_codes;
    wr_cfg(1'b0, 0, 1'b1, 32'hFFFF_FFFF);
    for (int c = 0; c < 4; c++) begin
      wr_cfg(1'b1, 32'(c) << 7 | 32'hFFFF_FE7F, 1'b0, 0);
      probe_cpu("R2 forwarding code", 32'hF100_0010);
      probe_cpu("R2 forwarding code", 32'hFA12_3456);
    end
  endtask

  task automatic t_window_sweep;
    wr_cfg(1'b1, 32'h80, 1'b0, 0);
    for (int n = 1; n <= 30; n++) begin
      wr_cfg(1'b0, 0, 1'b1, 32'(1) << n);
      probe_cpu("R3 window hit", 32'hF000_0000 + 32'(n) * MIB8);
      probe_cpu("R3 window hit", 32'hF000_0000 + 32'(n + 1) * MIB8 - 1);
      probe_cpu("R3 neighbour miss", 32'hF000_0000 + 32'(n - 1) * MIB8 + 32'h40);
      probe_cpu("R5 passthrough", 32'hF000_0000 + 32'(n) * MIB8 + 32'h1234);
    end
  endtask

  task automatic t_edge_bits;
    wr_cfg(1'b1, 32'h80, 1'b1, 32'hFFFF_FFFF);
    probe_cpu("R4 bit0 ignored", 32'hF000_0000);
    probe_cpu("R4 bit0 ignored", 32'hF07F_FFFF);
    probe_cpu("R4 bit31 ignored", 32'hFF80_0000);
    probe_cpu("R4 bit31 ignored", 32'hFFFF_FFFF);
    probe_cpu("R4 inner still hits", 32'hF080_0000);
    wr_cfg(1'b0, 0, 1'b1, 32'h8000_0001);
    probe_cpu("R4 only edge bits", 32'hF000_0100);
    probe_cpu("R4 only edge bits", 32'hFF90_0000);
  endtask

  task automatic t_outside;
    wr_cfg(1'b1, 32'h80, 1'b1, 32'hFFFF_FFFF);
    probe_cpu("R7 below aperture", 32'h0000_0000);
    probe_cpu("R7 below aperture", 32'h7080_0000);
    probe_cpu("R7 below aperture", 32'hEFFF_FFFF);
    cpu_addr = 32'hF100_0000; cpu_req = 1'b0; #1;
    check("R12 cpu idle", {63'd0, cpu_hit}, 64'd0);
  endtask

  task automatic t_same_cycle;
    wr_cfg(1'b1, 32'h80, 1'b1, 32'h0000_0004);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = 32'hF100_0000;
    bm_req = 1'b1; bm_addr = 32'hF100_0000;
    cfg_ctrl_we = 1'b1; cfg_ctrl_wdata = 32'h0;
    #1;
    check("R6 old ctrl in write cycle", {63'd0, cpu_hit}, 64'd1);
    check("R9 bm during reconfig", {63'd0, bm_sel_pcimem}, 64'd1);
    @(negedge clk);
    cfg_ctrl_we = 1'b0; m_ctrl = 0;
    #1;
    check("R6 new ctrl next cycle", {63'd0, cpu_hit}, 64'd0);
    check("R9 bm after reconfig", {63'd0, bm_sel_pcimem}, 64'd1);
    cfg_ctrl_we = 1'b1; cfg_ctrl_wdata = 32'h80;
    cfg_mask_we = 1'b1; cfg_mask_wdata = 32'h0000_0008;
    #1;
    check("R6 old config in write cycle", {63'd0, cpu_hit}, 64'd0);
    @(negedge clk);
    cfg_ctrl_we = 1'b0; cfg_mask_we = 1'b0;
    m_ctrl = 32'h80; m_mask = 32'h8;
    #1;
    check("R6 new mask next cycle", {63'd0, cpu_hit}, 64'd0);
    cpu_addr = 32'hF180_0000; #1;
    check("R6 new mask next cycle", {63'd0, cpu_hit}, 64'd1);
    cpu_req = 1'b0; bm_req = 1'b0;
  endtask

  task automatic t_inbound;
    wr_cfg(1'b1, 32'h0, 1'b1, 32'h0);
    probe_bm("R8 sysmem", 32'h0000_0000);
    probe_bm("R8 sysmem", 32'hF07F_FFFF);
    probe_bm("R9 pcimem", 32'hF080_0000);
    probe_bm("R9 pcimem", 32'hFF7F_FFFF);
    probe_bm("R11 gap miss", 32'hFF80_0000);
    probe_bm("R11 gap miss", 32'hFFEF_FFFF);
    probe_bm("R10 cpulocal", 32'hFFF0_0000);
    probe_bm("R10 cpulocal", 32'hFFFF_EFFF);
    probe_bm("R11 top miss", 32'hFFFF_F000);
    probe_bm("R11 top miss", 32'hFFFF_FFFF);
    bm_req = 1'b0; bm_addr = 32'hFFF0_0000; #1;
    check("R12 bm idle",
          {60'd0, bm_miss, bm_sel_cpulocal, bm_sel_pcimem, bm_sel_sysmem}, 64'd0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gate_codes();
    t_window_sweep();
    t_edge_bits();
    t_outside();
    t_same_cycle();
    t_inbound();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule